// File: doc/BRIEF.md
# PCI Configuration Target Decoder

This block is the target-side logic that lets a PCI function claim Type 0 configuration read and write cycles. It watches the shared address/data bus, the command/byte-enable lines, FRAME, IRDY and its own IDSEL input. It decides whether a cycle is meant for it and answers with DEVSEL, TRDY, STOP and read data. Each implemented function owns a private space of 64 dwords. The bus pins are split into separate input, output and output-enable signals, so the pad logic is left to the surrounding chip.

Selection comes only from the IDSEL input, which the system board wires to one of the upper AD lines. The block never compares the address against a base. Only the low eleven AD bits are decoded: a dword index and a function number. Every access moves exactly one dword. If the master tries to continue, the block disconnects it. The first dword of every function holds fixed identification values that software cannot change.

Top module: `pcfg_target`

## Requirements
- R1: A cycle is claimed only when all of these hold at the first clock edge where `frame_n` is sampled low after being high: `idsel` is high, `cbe_n` is 4'b1010 (config read) or 4'b1011 (config write), and `ad_in[1:0]` is 2'b00. If any condition fails, `devsel_n` stays high for the whole cycle.
- R2: `ad_in[31:11]` has no effect on the claim decision, on the function chosen or on the register chosen.
- R3: In the address phase, `ad_in[7:2]` selects the dword index and `ad_in[10:8]` selects the function. Each function keeps its own storage, and a read returns the dword most recently written at that index of that function.
- R4: A function number of `NUM_FUNC` or higher is never claimed. A write aimed at such a function changes no stored dword.
- R5: Decode timing is medium. Call the address-phase edge E0. At E0+2, `devsel_n` and `trdy_n` are first sampled low, and for a read `ad_oe` is high with the addressed dword on `ad_out`.
- R6: On a write, byte lane b (bits 8b+7..8b) of the stored dword takes the value on `ad_in` only when `cbe_n[b]` is 0 at the transfer edge. The other lanes keep their old value.
- R7: Dword index 0 of every function reads as {`DEVICE_ID`, `VENDOR_ID`} (device in bits 31:16), and writes to it are ignored.
- R8: If `frame_n` is still low at the edge where the single dword transfers, the next edge shows `stop_n` low with `trdy_n` high. `devsel_n` and `stop_n` stay low until `frame_n` is sampled high, and then both are released at that edge.
- R9: If `frame_n` is high at the transfer edge, then `devsel_n` and `trdy_n` are high and `ad_oe` is low at the next edge.
- R10: While `rst` is high, `devsel_n`, `trdy_n` and `stop_n` are high and `ad_oe` is low.
- R11: Once asserted, `trdy_n` and `devsel_n` are held low until the master asserts `irdy_n`. No transfer and no write happen before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle framing, active low |
| irdy_n | input | 1 | Master ready, active low |
| idsel | input | 1 | Configuration select for this device |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| ad_in | input | 32 | Address/data bus as seen by the device |
| ad_out | output | 32 | Read data to the bus |
| ad_oe | output | 1 | Enables the device's AD drivers |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop (disconnect), active low |

## Verification
Reads and writes are run against both functions at the same index, which shows whether the function field really selects separate storage. Full-width and sparse byte-enable writes tell a correct per-lane merge apart from a whole-word store. Address phases that carry junk in the high AD bits, a low IDSEL, a wrong command, a nonzero low address pair or an unimplemented function each separate a decoder that uses only IDSEL and the low eleven bits from one that looks at more, or at less. A delayed IRDY shows whether the target waits for the master. A FRAME held low through the data phase shows whether a continuing burst ends in a disconnect with exactly one dword moved.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA, ST_DISC} seq_state_t;
  localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;
  localparam int IDX_W = 6;
  localparam int FN_W  = 3;
endpackage

// File: rtl/pcfg_claim.sv
// Combinational address-phase decode: low eleven AD bits plus IDSEL only.
module pcfg_claim
  import pcfg_pkg::*;
#(
  parameter int NUM_FUNC = 2
) (
  input  logic [10:0]      ad_lo,
  input  logic [3:0]       cbe_n,
  input  logic             idsel,
  output logic             hit,
  output logic             is_write,
  output logic [FN_W-1:0]  func,
  output logic [IDX_W-1:0] idx
);
  localparam logic [FN_W:0] FN_LIMIT = (FN_W+1)'(NUM_FUNC);

  logic cmd_ok;
  logic fn_ok;

  assign func     = ad_lo[10:8];
  assign idx      = ad_lo[7:2];
  assign cmd_ok   = (cbe_n == CMD_CFG_READ) || (cbe_n == CMD_CFG_WRITE);
  assign fn_ok    = ({1'b0, func} < FN_LIMIT);
  assign hit      = idsel && cmd_ok && (ad_lo[1:0] == 2'b00) && fn_ok;
  assign is_write = cbe_n[0];
endmodule

// File: rtl/pcfg_store.sv
// Dword storage split into byte lanes so each lane infers its own RAM.
module pcfg_store #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LANES-1:0]   be,
  input  logic [AW-1:0]      waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [8*LANES-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    initial begin
      for (int k = 0; k < DEPTH; k++) lane_mem[k] = 8'h00;
    end

    always_ff @(posedge clk) begin
      if (we && be[g]) lane_mem[waddr] <= wdata[8*g +: 8];
      rdata[8*g +: 8] <= lane_mem[raddr];
    end
  end
endmodule

// File: rtl/pcfg_seq.sv
// Target sequencer: medium DEVSEL, one data phase, disconnect on burst.
module pcfg_seq
  import pcfg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic hit,
  input  logic hit_write,
  output logic take,
  output logic mem_we,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic ad_oe
);
  seq_state_t st;
  logic       frame_q;
  logic       wr_q;

  assign take   = (st == ST_IDLE) && frame_q && !frame_n && hit;
  assign mem_we = (st == ST_DATA) && !irdy_n && wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      frame_q  <= 1'b1;
      wr_q     <= 1'b0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ad_oe    <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (st)
        ST_IDLE: if (take) begin
          wr_q <= hit_write;
          st   <= ST_WAIT;
        end
        ST_WAIT: begin
          devsel_n <= 1'b0;
          trdy_n   <= 1'b0;
          ad_oe    <= !wr_q;
          st       <= ST_DATA;
        end
        ST_DATA: if (!irdy_n) begin
          trdy_n <= 1'b1;
          ad_oe  <= 1'b0;
          if (frame_n) begin
            devsel_n <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            stop_n <= 1'b0;
            st     <= ST_DISC;
          end
        end
        ST_DISC: if (frame_n) begin
          devsel_n <= 1'b1;
          stop_n   <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcfg_target.sv
module pcfg_target
  import pcfg_pkg::*;
#(
  parameter int          NUM_FUNC  = 2,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID = 16'h7E21
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n
);
  localparam int REGS  = 1 << IDX_W;
  localparam int DEPTH = NUM_FUNC * REGS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             hit, hit_write, take, seq_we;
  logic [FN_W-1:0]  dec_fn, fn_q;
  logic [IDX_W-1:0] dec_idx, idx_q;
  logic             ro_q;
  logic [AW-1:0]    mem_addr;
  logic [31:0]      mem_rdata;

  pcfg_claim #(.NUM_FUNC(NUM_FUNC)) u_claim (
    .ad_lo    (ad_in[10:0]),
    .cbe_n    (cbe_n),
    .idsel    (idsel),
    .hit      (hit),
    .is_write (hit_write),
    .func     (dec_fn),
    .idx      (dec_idx)
  );

  pcfg_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .hit       (hit),
    .hit_write (hit_write),
    .take      (take),
    .mem_we    (seq_we),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .ad_oe     (ad_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q  <= '0;
      idx_q <= '0;
      ro_q  <= 1'b0;
    end else if (take) begin
      fn_q  <= dec_fn;
      idx_q <= dec_idx;
      ro_q  <= (dec_idx == '0);
    end
  end

  assign mem_addr = AW'({fn_q, idx_q});

  pcfg_store #(.DEPTH(DEPTH), .AW(AW), .LANES(4)) u_store (
    .clk   (clk),
    .we    (seq_we && !ro_q),
    .be    (~cbe_n),
    .waddr (mem_addr),
    .wdata (ad_in),
    .raddr (mem_addr),
    .rdata (mem_rdata)
  );

  assign ad_out = ro_q ? {DEVICE_ID, VENDOR_ID} : mem_rdata;
endmodule

// File: rtl/pcfg_target_chk.sv
module pcfg_target_chk #(
  parameter int NUM_FUNC = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        idsel,
  input logic [3:0]  cbe_n,
  input logic [31:0] ad_in,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        stop_n
);
  assert_claim_needs_idsel_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> (!$past(frame_n, 2) && $past(idsel, 2)
                         && ($past(cbe_n, 2) == 4'b1010 || $past(cbe_n, 2) == 4'b1011)));

  assert_claim_fn_range_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> (int'($past(ad_in[10:8], 2)) < NUM_FUNC));

  assert_trdy_with_devsel_R5: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);

  assert_oe_with_devsel_R5: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !devsel_n);

  assert_stop_shape_R8: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> (!devsel_n && trdy_n && !ad_oe));

  assert_single_release_R9: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe));

  assert_wait_for_master_R11: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && irdy_n) |=> (!trdy_n && !devsel_n));

  assert_reset_idle_R10: assert property (@(posedge clk)
    $past(rst) |-> (devsel_n && trdy_n && stop_n && !ad_oe));
endmodule

bind pcfg_target pcfg_target_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (.*);

// File: tb/sim_pcfg_target.sv
`timescale 1ns/1ps
module sim_pcfg_target;
  localparam int          NF  = 2;
  localparam logic [15:0] VEN = 16'hA5C3;
  localparam logic [15:0] DEV = 16'h7E21;
  localparam logic [31:0] IDW = {DEV, VEN};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe_n = 4'h0;
  logic [31:0] ad_in = 32'h0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n;

  int checks = 0;
  int fails  = 0;
  int dev_seen = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  pcfg_target #(.NUM_FUNC(NF), .VENDOR_ID(VEN), .DEVICE_ID(DEV)) u0 (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  logic [31:0] mm [8][64];
  int m_ph = 0, m_f = 0, m_i = 0;
  bit m_w = 0, m_fq = 1;
  bit e_dev = 1, e_trdy = 1, e_stop = 1, e_oe = 0;

  initial begin
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 64; i++) mm[f][i] = 32'h0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_fq = 1; e_dev = 1; e_trdy = 1; e_stop = 1; e_oe = 0;
    end else begin
      if (m_ph == 0) begin
        if (m_fq && !frame_n && idsel && (cbe_n == 4'b1010 || cbe_n == 4'b1011)
            && ad_in[1:0] == 2'b00 && int'(ad_in[10:8]) < NF) begin
          m_ph = 1; m_f = int'(ad_in[10:8]); m_i = int'(ad_in[7:2]); m_w = cbe_n[0];
        end
      end else if (m_ph == 1) begin
        m_ph = 2; e_dev = 0; e_trdy = 0; e_oe = !m_w;
      end else if (m_ph == 2) begin
        if (!irdy_n) begin
          if (m_w && m_i != 0)
            for (int b = 0; b < 4; b++)
              if (!cbe_n[b]) mm[m_f][m_i][8*b +: 8] = ad_in[8*b +: 8];
          e_trdy = 1; e_oe = 0;
          if (frame_n) begin e_dev = 1; m_ph = 0; end
          else begin e_stop = 0; m_ph = 3; end
        end
      end else begin
        if (frame_n) begin e_dev = 1; e_stop = 1; m_ph = 0; end
      end
      m_fq = frame_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && devsel_n === 1'b0) dev_seen++;
    if (cmp_on) begin
      chk("R5 devsel_n vs model", 32'(devsel_n), 32'(e_dev));
      chk("R11 trdy_n vs model", 32'(trdy_n), 32'(e_trdy));
      chk("R8 stop_n vs model", 32'(stop_n), 32'(e_stop));
      chk("R9 ad_oe vs model", 32'(ad_oe), 32'(e_oe));
      if (e_oe) chk("R3 ad_out vs model", ad_out, (m_i == 0) ? IDW : mm[m_f][m_i]);
    end
  end

  function automatic logic [31:0] mk_addr(input logic [20:0] hi, input int fn,
                                          input int idx, input logic [1:0] lo);
    return {hi, 3'(fn), 6'(idx), lo};
  endfunction

  task automatic cfg_cycle(input logic [3:0] cmd, input bit sel, input logic [31:0] addr,
                           input logic [31:0] wdata, input logic [3:0] be_n,
                           input int irdy_wait, input bit burst, input bit exp_claim,
                           input string tag, output logic [31:0] rdata);
    bit got = 0;
    rdata = 32'hFFFF_FFFF;
    @(negedge clk);
    dev_seen = 0;
    frame_n = 1'b0; idsel = sel; ad_in = addr; cbe_n = cmd; irdy_n = 1'b1;
    @(negedge clk);
    chk({tag, " devsel high one edge after address"}, 32'(devsel_n), 32'd1);
    idsel = 1'b0; cbe_n = be_n; ad_in = cmd[0] ? wdata : 32'h5A5A_0F0F;
    if (irdy_wait == 0) begin irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1; end
    for (int k = 1; k <= irdy_wait + 6; k++) begin
      @(negedge clk);
      if (k == 1)
        chk({tag, " R5 medium decode devsel/trdy"}, {30'd0, devsel_n, trdy_n},
            exp_claim ? 32'd0 : 32'd3);
      if (k == irdy_wait) begin irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1; end
      if (exp_claim && !irdy_n && !trdy_n) begin
        if (ad_oe) rdata = ad_out;
        got = 1;
        break;
      end
    end
    if (exp_claim) chk({tag, " transfer reached"}, 32'(got), 32'd1);
    @(negedge clk);
    if (exp_claim && burst) begin
      chk({tag, " R8 stop with trdy released"}, {30'd0, stop_n, trdy_n}, 32'd1);
      frame_n = 1'b1;
      @(negedge clk);
      irdy_n = 1'b1;
      chk({tag, " R8 release after frame high"}, {30'd0, stop_n, devsel_n}, 32'd3);
    end else begin
      if (exp_claim)
        chk({tag, " R9 released after last transfer"}, {30'd0, devsel_n, trdy_n, ad_oe}, 32'd6);
      frame_n = 1'b1;
      irdy_n  = 1'b1;
    end
    cbe_n = 4'h0; ad_in = 32'h0;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " claim seen"}, 32'(dev_seen > 0), 32'(exp_claim));
  endtask

  task automatic rd(input logic [31:0] addr, input bit sel, input bit exp_claim,
                    input int wt, input bit burst, input string tag,
                    input logic [31:0] exp);
    logic [31:0] v;
    cfg_cycle(4'b1010, sel, addr, 32'h0, 4'h0, wt, burst, exp_claim, tag, v);
    chk({tag, " read data"}, v, exp);
  endtask

  task automatic wr(input logic [31:0] addr, input bit sel, input bit exp_claim,
                    input logic [31:0] d, input logic [3:0] be_n, input bit burst,
                    input string tag);
    logic [31:0] v;
    cfg_cycle(4'b1011, sel, addr, d, be_n, 0, burst, exp_claim, tag, v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset outputs", {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);

    rd(mk_addr(21'h0, 0, 0, 2'b00), 1, 1, 0, 0, "R7 id f0", IDW);
    rd(mk_addr(21'h0, 1, 0, 2'b00), 1, 1, 0, 0, "R7 id f1", IDW);
    wr(mk_addr(21'h0, 0, 5, 2'b00), 1, 1, 32'h1234_5678, 4'b0000, 0, "R3 wr f0");
    wr(mk_addr(21'h0, 1, 5, 2'b00), 1, 1, 32'hCAFE_F00D, 4'b0000, 0, "R3 wr f1");
    rd(mk_addr(21'h0, 0, 5, 2'b00), 1, 1, 0, 0, "R3 rd f0", 32'h1234_5678);
    rd(mk_addr(21'h0, 1, 5, 2'b00), 1, 1, 0, 0, "R3 rd f1", 32'hCAFE_F00D);
    wr(mk_addr(21'h0, 0, 5, 2'b00), 1, 1, 32'hAABB_CCDD, 4'b1010, 0, "R6 sparse wr");
    rd(mk_addr(21'h0, 0, 5, 2'b00), 1, 1, 0, 0, "R6 merged", 32'h12BB_56DD);
    wr(mk_addr(21'h0, 0, 0, 2'b00), 1, 1, 32'hFFFF_FFFF, 4'b0000, 0, "R7 wr id");
    rd(mk_addr(21'h0, 0, 0, 2'b00), 1, 1, 0, 0, "R7 id kept", IDW);
    rd(mk_addr(21'h1ABCDE, 1, 5, 2'b00), 1, 1, 0, 0, "R2 junk hi rd", 32'hCAFE_F00D);
    wr(mk_addr(21'h15A5A5, 0, 9, 2'b00), 1, 1, 32'h0F0F_0F0F, 4'b0000, 0, "R2 junk hi wr");
    rd(mk_addr(21'h0, 0, 9, 2'b00), 1, 1, 0, 0, "R2 clean rd", 32'h0F0F_0F0F);
    rd(mk_addr(21'h0, 0, 9, 2'b00), 0, 0, 0, 0, "R1 idsel low", 32'hFFFF_FFFF);
    wr(mk_addr(21'h0, 0, 9, 2'b00), 0, 0, 32'h7777_7777, 4'b0000, 0, "R1 idsel low wr");
    rd(mk_addr(21'h0, 0, 9, 2'b00), 1, 1, 0, 0, "R1 unchanged", 32'h0F0F_0F0F);
    begin
      logic [31:0] v;
      cfg_cycle(4'b0110, 1, mk_addr(21'h0, 0, 9, 2'b00), 32'h0, 4'h0, 0, 0, 0, "R1 bad cmd", v);
    end
    rd(mk_addr(21'h0, 0, 9, 2'b01), 1, 0, 0, 0, "R1 low bits", 32'hFFFF_FFFF);
    rd(mk_addr(21'h0, 5, 5, 2'b00), 1, 0, 0, 0, "R4 fn5 rd", 32'hFFFF_FFFF);
    wr(mk_addr(21'h0, 5, 5, 2'b00), 1, 0, 32'h1111_1111, 4'b0000, 0, "R4 fn5 wr");
    rd(mk_addr(21'h0, 1, 5, 2'b00), 1, 1, 0, 0, "R4 f1 unchanged", 32'hCAFE_F00D);
    rd(mk_addr(21'h0, 0, 5, 2'b00), 1, 1, 0, 0, "R4 f0 unchanged", 32'h12BB_56DD);
    rd(mk_addr(21'h0, 0, 9, 2'b00), 1, 1, 3, 0, "R11 irdy wait", 32'h0F0F_0F0F);
    wr(mk_addr(21'h0, 0, 12, 2'b00), 1, 1, 32'h1111_2222, 4'b0000, 1, "R8 burst wr");
    rd(mk_addr(21'h0, 0, 12, 2'b00), 1, 1, 0, 0, "R8 one dword", 32'h1111_2222);
    rd(mk_addr(21'h0, 1, 5, 2'b00), 1, 1, 2, 1, "R8 burst rd", 32'hCAFE_F00D);

    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule